// File: doc/BRIEF.md
# Descriptor Chain Fetch Engine

This engine walks a chain of descriptors held in word-addressed memory and turns it into a stream of transfer commands for a downstream data mover. A pulse on `start` with a start address begins the walk. For each descriptor the engine reads six words, checks the header's parity, and then handles two slots. The first slot is the input (read) side and the second is the output (write) side. Each slot holds either a direct buffer or the head of a linked list of link records. Every command carries the buffer address, the byte length, the direction, and the encrypt and chaining-mode bits taken from the header.

When a descriptor has a zero next pointer, the walk ends with a one-cycle `done` pulse. On any failure the engine halts. It keeps a 4-bit failure code on `err_code` until `err_clr` is pulsed. Memory is read one word at a time through a request/response port with any latency. Commands leave through a valid/ready handshake.

Top module: `desc_walker`

## Requirements
- R1: A descriptor is six consecutive 32-bit words at ascending word addresses: header, length 1, pointer 1, length 2, pointer 2, next-descriptor address. The engine reads them in that order, starting at the given address.
- R2: A header is accepted only if its 32 bits contain an odd number of ones (bit 31 is the parity bit). An even count halts the engine with code 1, and no command is issued for that descriptor.
- R3: When header bit 24 is set, each slot is direct. The engine issues one command with address equal to the slot pointer and length equal to the slot length.
- R4: A slot whose length and pointer are both zero is skipped and produces no command. This applies in direct and in list mode.
- R5: When header bit 24 is clear, a slot pointer addresses a link record of three words: length, data pointer, next-link address. The engine issues one command per record, follows the next-link address, and ends that slot's list at a zero next-link address.
- R6: Commands from slot 1 have `cmd_write`=0 and commands from slot 2 have `cmd_write`=1. `cmd_enc` equals header bit 2 and `cmd_cbc` equals header bit 3.
- R7: A non-zero next-descriptor address causes the next descriptor to be fetched. A zero next-descriptor address ends the walk with `done` high for exactly one cycle.
- R8: A link record with length zero halts with code 4. A link record with data pointer zero (and non-zero length) halts with code 5.
- R9: A descriptor address (start or next) with bits [1:0] not zero halts with code 12. A link address (slot head or next-link) with bits [1:0] not zero halts with code 13. Every memory read address is word aligned.
- R10: While halted, `err` stays high, `err_code` stays stable and non-zero, and no memory read or command is issued. A pulse on `err_clr` returns the engine to idle with `err`=0 and `err_code`=0.
- R11: A command stays valid with stable address and length until `cmd_ready` accepts it. No memory read is issued while a command is pending.
- R12: At most one memory read is outstanding; `mem_req` is never high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a walk (honoured when idle) |
| start_addr | input | W | Address of the first descriptor |
| err_clr | input | 1 | Leave the halted state |
| mem_req | output | 1 | One-cycle word read request |
| mem_addr | output | W | Byte address of the requested word |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | W | Read data |
| cmd_valid | output | 1 | Transfer command valid |
| cmd_ready | input | 1 | Command accepted by the data mover |
| cmd_addr | output | W | Buffer address |
| cmd_len | output | W | Byte length |
| cmd_write | output | 1 | 1 = output (write) side, 0 = input (read) side |
| cmd_enc | output | 1 | Encrypt flag from the header |
| cmd_cbc | output | 1 | Chaining-mode flag from the header |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle end-of-chain pulse |
| err | output | 1 | Halted on a failure |
| err_code | output | 4 | Failure source code |

## Verification
The bench builds a two-descriptor chain that mixes a direct key descriptor with a list-mode data descriptor, and it stalls the command handshake throughout that chain. A design that dropped the second list record, or that swapped the slot directions, would produce an out-of-order scoreboard entry. So would a design that changed the command while it was stalled. A decrypt chain with a skipped first slot catches an engine that emits a zero-length command. Separate descriptors fail in each of four ways: wrong parity, a zero link length, a null link data pointer, and misaligned descriptor or link addresses, including misaligned next pointers met in the middle of a walk. Each failure must give its own code after exactly the commands that came before it. The halt must also hold off reads until the clear pulse.

// File: rtl/desc_walker.sv
module desc_walker #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [W-1:0] start_addr,
  input  logic         err_clr,
  output logic         mem_req,
  output logic [W-1:0] mem_addr,
  input  logic         mem_rvalid,
  input  logic [W-1:0] mem_rdata,
  output logic         cmd_valid,
  input  logic         cmd_ready,
  output logic [W-1:0] cmd_addr,
  output logic [W-1:0] cmd_len,
  output logic         cmd_write,
  output logic         cmd_enc,
  output logic         cmd_cbc,
  output logic         busy,
  output logic         done,
  output logic         err,
  output logic [3:0]   err_code
);
  localparam int DWORDS = 6;
  localparam int LWORDS = 3;
  localparam logic [3:0] E_HDR = 4'd1, E_LLEN = 4'd4, E_LPTR = 4'd5,
                         E_DADR = 4'd12, E_LADR = 4'd13;

  typedef enum logic [3:0] {S_IDLE, S_DREQ, S_DWAIT, S_CHK, S_SLOT, S_LREQ,
                            S_LWAIT, S_LCHK, S_CMD, S_ADV, S_HALT} st_t;
  st_t st;

  logic [W-1:0] dw [DWORDS];
  logic [W-1:0] lw [LWORDS];
  logic [2:0]   idx;
  logic [W-1:0] base;
  logic         slot, via_link;

  wire [W-1:0] hdr   = dw[0];
  wire [W-1:0] s_len = slot ? dw[3] : dw[1];
  wire [W-1:0] s_ptr = slot ? dw[4] : dw[2];
  wire unused_hdr    = ^{hdr[31:25], hdr[23:4], hdr[1:0]};

  assign mem_req   = (st == S_DREQ) || (st == S_LREQ);
  assign mem_addr  = base + (W'(idx) << 2);
  assign cmd_valid = (st == S_CMD);
  assign cmd_write = slot;
  assign cmd_enc   = hdr[2];
  assign cmd_cbc   = hdr[3];
  assign err       = (st == S_HALT);
  assign busy      = (st != S_IDLE) && (st != S_HALT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; idx <= '0; base <= '0; slot <= 1'b0; via_link <= 1'b0;
      done <= 1'b0; err_code <= '0; cmd_addr <= '0; cmd_len <= '0;
      for (int i = 0; i < DWORDS; i++) dw[i] <= '0;
      for (int i = 0; i < LWORDS; i++) lw[i] <= '0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          base <= start_addr; idx <= '0; err_code <= '0;
          if (start_addr[1:0] != 2'b00) begin err_code <= E_DADR; st <= S_HALT; end
          else st <= S_DREQ;
        end
        S_DREQ: st <= S_DWAIT;
        S_DWAIT: if (mem_rvalid) begin
          dw[idx] <= mem_rdata;
          if (idx == 3'(DWORDS - 1)) st <= S_CHK;
          else begin idx <= idx + 3'd1; st <= S_DREQ; end
        end
        S_CHK: begin
          slot <= 1'b0;
          if (!(^hdr)) begin err_code <= E_HDR; st <= S_HALT; end
          else st <= S_SLOT;
        end
        S_SLOT: begin
          if (s_len == '0 && s_ptr == '0) st <= S_ADV;
          else if (hdr[24]) begin
            cmd_addr <= s_ptr; cmd_len <= s_len; via_link <= 1'b0; st <= S_CMD;
          end else if (s_ptr[1:0] != 2'b00) begin
            err_code <= E_LADR; st <= S_HALT;
          end else begin
            base <= s_ptr; idx <= '0; st <= S_LREQ;
          end
        end
        S_LREQ: st <= S_LWAIT;
        S_LWAIT: if (mem_rvalid) begin
          lw[idx] <= mem_rdata;
          if (idx == 3'(LWORDS - 1)) st <= S_LCHK;
          else begin idx <= idx + 3'd1; st <= S_LREQ; end
        end
        S_LCHK: begin
          if (lw[0] == '0) begin err_code <= E_LLEN; st <= S_HALT; end
          else if (lw[1] == '0) begin err_code <= E_LPTR; st <= S_HALT; end
          else begin
            cmd_addr <= lw[1]; cmd_len <= lw[0]; via_link <= 1'b1; st <= S_CMD;
          end
        end
        S_CMD: if (cmd_ready) begin
          if (via_link && lw[2] != '0) begin
            if (lw[2][1:0] != 2'b00) begin err_code <= E_LADR; st <= S_HALT; end
            else begin base <= lw[2]; idx <= '0; st <= S_LREQ; end
          end else st <= S_ADV;
        end
        S_ADV: begin
          if (!slot) begin slot <= 1'b1; st <= S_SLOT; end
          else if (dw[5] == '0) begin done <= 1'b1; st <= S_IDLE; end
          else if (dw[5][1:0] != 2'b00) begin err_code <= E_DADR; st <= S_HALT; end
          else begin base <= dw[5]; idx <= '0; st <= S_DREQ; end
        end
        S_HALT: if (err_clr) begin err_code <= '0; st <= S_IDLE; end
        default: st <= S_IDLE;
      endcase
    end
  end

  p_cmd_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_addr) && $stable(cmd_len));
  p_no_read_in_cmd_r11: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> !mem_req);
  p_one_read_r12: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |=> !mem_req);
  p_aligned_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> mem_addr[1:0] == 2'b00);
  p_halt_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    err && !err_clr |=> err && $stable(err_code));
  p_halt_code_r10: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> err_code != 4'd0 && !mem_req && !cmd_valid);
  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

// File: tb/desc_walker_test.sv
module desc_walker_test;
  localparam int W = 32;
  logic clk = 0, rst_n = 0, start = 0, err_clr = 0;
  logic [W-1:0] start_addr = '0;
  logic mem_req, mem_rvalid, cmd_valid, cmd_ready, cmd_write, cmd_enc, cmd_cbc;
  logic busy, done, err;
  logic [W-1:0] mem_addr, mem_rdata, cmd_addr, cmd_len;
  logic [3:0] err_code;

  desc_walker #(.W(W)) uut (.*);

  always #2 clk = ~clk;

  int total = 0, bad = 0, reads = 0, cyc = 0;
  string cur_tag = "R3";
  logic stall = 0;
  logic [W-1:0] mem [256];
  logic [66:0] exp_q[$];

  assign cmd_ready = stall ? cyc[0] : 1'b1;
  always @(posedge clk) cyc <= cyc + 1;

  logic pv = 0, rv = 0;
  logic [W-1:0] pd = '0, rd = '0;
  assign mem_rvalid = rv;
  assign mem_rdata  = rd;
  always @(negedge clk) begin
    rv <= pv; rd <= pd;
    pv <= mem_req; pd <= mem[mem_addr[9:2]];
    if (mem_req) reads++;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [66:0] act, input logic [66:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) if (cmd_valid && cmd_ready) begin
    logic [66:0] a;
    a = {cmd_addr, cmd_len, cmd_write, cmd_enc, cmd_cbc};
    if (exp_q.size() == 0) chk(0, cur_tag, "unexpected command", a, '0);
    else begin
      logic [66:0] e;
      e = exp_q.pop_front();
      chk(a == e, cur_tag, "command", a, e);
    end
  end

  function automatic logic [31:0] mkhdr(input bit direct, input bit [3:0] fmt,
                                        input bit enc, input bit cbc);
    logic [31:0] h;
    h = '0;
    h[24] = direct; h[19:16] = fmt; h[29:28] = 2'd1; h[2] = enc; h[3] = cbc;
    h[31] = ~(^h[30:0]);
    return h;
  endfunction

  task automatic put_desc(input int a, input logic [31:0] h, l1, p1, l2, p2, nx);
    mem[a/4] = h; mem[a/4+1] = l1; mem[a/4+2] = p1;
    mem[a/4+3] = l2; mem[a/4+4] = p2; mem[a/4+5] = nx;
  endtask
  task automatic put_link(input int a, input logic [31:0] l, p, nx);
    mem[a/4] = l; mem[a/4+1] = p; mem[a/4+2] = nx;
  endtask
  task automatic expc(input logic [31:0] a, l, input bit wr, enc, cbc);
    exp_q.push_back({a, l, wr, enc, cbc});
  endtask

  task automatic go(input logic [31:0] sa, input logic [3:0] ecode, input string tag);
    int n = 0;
    cur_tag = tag;
    @(negedge clk) begin start = 1; start_addr = sa; end
    @(negedge clk) start = 0;
    while (!done && !err && n < 3000) begin @(negedge clk); n++; end
    if (ecode == 0) chk(done && !err, tag, "completion", {63'd0, err_code}, 67'd0);
    else chk(err && err_code == ecode, tag, "error code", {63'd0, err_code}, {63'd0, ecode});
    chk(exp_q.size() == 0, tag, "commands left", 67'(exp_q.size()), 67'd0);
    exp_q.delete();
    if (ecode != 0) begin
      int was = reads;
      repeat (4) @(negedge clk);
      chk(err && err_code == ecode && !cmd_valid && reads == was, "R10", "halt holds",
          {63'd0, err_code}, {63'd0, ecode});
      err_clr = 1; @(negedge clk); err_clr = 0;
      chk(!err && err_code == 0 && !busy, "R10", "cleared", {62'd0, err, err_code}, 67'd0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk(0, "WD", "watchdog expired", 67'd0, 67'd1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    chk(!done && !err && !busy && !cmd_valid && !mem_req && err_code == 0,
        "R10", "reset state", {63'd0, err_code}, 67'd0);
    rst_n = 1;

    // R3 R5 R6 R7 R11: direct key descriptor then list-mode data descriptor, stalled
    put_desc(32'h000, mkhdr(1, 4'd8, 1, 1), 16, 32'h1000, 16, 32'h2000, 32'h018);
    put_desc(32'h018, mkhdr(0, 4'd5, 1, 1), 80, 32'h100, 80, 32'h140, 0);
    put_link(32'h100, 32, 32'h4000, 32'h10C);
    put_link(32'h10C, 48, 32'h5000, 0);
    put_link(32'h140, 80, 32'h6000, 0);
    expc(32'h1000, 16, 0, 1, 1); expc(32'h2000, 16, 1, 1, 1);
    expc(32'h4000, 32, 0, 1, 1); expc(32'h5000, 48, 0, 1, 1);
    expc(32'h6000, 80, 1, 1, 1);
    stall = 1; reads = 0;
    go(32'h000, 0, "R5");
    chk(reads == 21, "R1", "word reads", 67'(reads), 67'd21);
    stall = 0;

    // R4: ECB decrypt, first slot skipped
    put_desc(32'h040, mkhdr(1, 4'd8, 0, 0), 0, 0, 16, 32'h7000, 32'h058);
    put_desc(32'h058, mkhdr(1, 4'd5, 0, 0), 64, 32'h8000, 64, 32'h9000, 0);
    expc(32'h7000, 16, 1, 0, 0); expc(32'h8000, 64, 0, 0, 0); expc(32'h9000, 64, 1, 0, 0);
    go(32'h040, 0, "R4");

    // R2: bad parity
    put_desc(32'h080, mkhdr(1, 4'd5, 1, 0) ^ 32'h8000_0000, 16, 32'hC000, 16, 32'hD000, 0);
    go(32'h080, 4'd1, "R2");

    // R8: link length zero, link pointer zero
    put_desc(32'h0A0, mkhdr(0, 4'd5, 1, 0), 16, 32'h180, 0, 0, 0);
    put_link(32'h180, 0, 32'h4000, 0);
    go(32'h0A0, 4'd4, "R8");
    put_desc(32'h0C0, mkhdr(0, 4'd5, 1, 0), 16, 32'h190, 0, 0, 0);
    put_link(32'h190, 16, 0, 0);
    go(32'h0C0, 4'd5, "R8");

    // R9: misaligned start, misaligned next descriptor, misaligned link next and head
    go(32'h0E2, 4'd12, "R9");
    put_desc(32'h0E0, mkhdr(1, 4'd5, 1, 0), 16, 32'hA000, 0, 0, 32'h206);
    expc(32'hA000, 16, 0, 1, 0);
    go(32'h0E0, 4'd12, "R9");
    put_desc(32'h220, mkhdr(0, 4'd5, 0, 1), 16, 32'h1A0, 0, 0, 0);
    put_link(32'h1A0, 16, 32'hB000, 32'h1B1);
    expc(32'hB000, 16, 0, 0, 1);
    go(32'h220, 4'd13, "R9");
    put_desc(32'h240, mkhdr(0, 4'd5, 0, 1), 16, 32'h1C2, 0, 0, 0);
    go(32'h240, 4'd13, "R9");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule